// File: doc/BRIEF.md
# Branch Transfer Classifier

This block sorts one recorded control-flow transfer into a class. It looks at the opcode bytes taken from the transfer's source address, how many of those bytes could be read, whether the source and target addresses are zero, whether the transfer was an abort, and the privilege level at each end. From these it produces a one-hot class vector and a two-bit target-privilege tag.

A sampling or trace filter uses the class and tag to keep or drop each recorded branch. The decoder examines only the opcode, a ModRM byte and a near-call displacement. Prefix bytes are assumed to be absent. The result is registered and is marked by a valid strobe one cycle after the input strobe.

A transfer from user level to kernel level is reported as an interrupt, trap or fault, unless its opcode is a system-call entry or a software interrupt. A relative near call with a zero displacement has a class of its own.

Top module: `brc_classifier`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low otherwise. Reset (synchronous, active high) clears `out_valid`, `out_class` and `out_plm`.
- R2: When `in_src_zero` or `in_dst_zero` is set, the result is none (`out_class` = 0, `out_plm` = 0). This takes priority over the abort flag.
- R3: When both addresses are nonzero and `in_abort` is set, the class is abort with the target privilege tag. The opcode bytes are ignored.
- R4: When there is no abort and `in_nbytes` = 0, the result is none. This holds even for a user-to-kernel transfer.
- R5: Byte k occupies `in_bytes[8k+7:8k]`. A first byte of 0F needs a second byte. A second byte of 05 or 34 gives syscall, 07 or 35 gives system return, and 80 through 8F gives conditional.
- R6: These single-byte opcodes map as follows. 70–7F and E0–E3 are conditional. C2, C3, CA and CB are return. CF is interrupt return. CC–CE are software interrupt. E9–EB are jump. 9A is call.
- R7: Opcode E8 needs 1 + D valid bytes, where D is 4 in both modes by default. If the little-endian displacement in bytes 1..D is zero, the class is zero-length call; otherwise it is call. `in_long_mode` does not change D at the default parameters.
- R8: For opcode FF with at least two bytes, bits 5:3 of byte 1 select the class. A value of 2 or 3 gives indirect call, 4 or 5 gives indirect jump, and any other value gives none.
- R9: Any other opcode, or too few valid bytes for the opcode, ModRM or displacement, gives none before the R10 step.
- R10: Suppose both addresses are nonzero, there is no abort, `in_nbytes` > 0, `in_src_kernel` = 0 and `in_dst_kernel` = 1. Then the class becomes interrupt/fault, unless the decoded class is syscall or software interrupt.
- R11: `out_plm` is 01 for a user target and 10 for a kernel target whenever the class is not none, and 00 when the class is none.
- R12: The `out_class` bit positions are: 0 call, 1 return, 2 syscall, 3 system return, 4 software interrupt, 5 interrupt return, 6 conditional, 7 jump, 8 interrupt/fault, 9 indirect call, 10 abort, 11 zero-length call, 12 indirect jump. At most one bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input transfer strobe |
| in_bytes | input | 48 | Opcode bytes, byte k at bits 8k+7:8k |
| in_nbytes | input | 3 | Number of readable bytes (0..6) |
| in_long_mode | input | 1 | Source code runs in 64-bit mode |
| in_src_kernel | input | 1 | Source address is kernel level |
| in_dst_kernel | input | 1 | Target address is kernel level |
| in_abort | input | 1 | Transfer was an abort |
| in_src_zero | input | 1 | Source address is zero |
| in_dst_zero | input | 1 | Target address is zero |
| out_valid | output | 1 | Result strobe |
| out_class | output | 13 | One-hot class, zero for none |
| out_plm | output | 2 | Target privilege tag: 01 user, 10 kernel |

## Verification
The embedded properties cover the rules that hold for every transfer and do not depend on the opcode. They check:
- the one-cycle strobe timing;
- that the class has at most one bit set and matches the privilege tag;
- the priority of the zero-address and abort rules;
- that a user-to-kernel transfer can only leave as interrupt/fault, syscall or software interrupt.

The opcode table itself needs the directed scenarios: both byte groups, the FF ModRM split, the zero and nonzero displacement of E8, and the byte-count limits. These can only be shown by applying chosen byte patterns and comparing each result with the value the requirements predict.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int NCLASS    = 13;
  localparam int C_CALL    = 0;
  localparam int C_RET     = 1;
  localparam int C_SYSCALL = 2;
  localparam int C_SYSRET  = 3;
  localparam int C_SWINT   = 4;
  localparam int C_IRET    = 5;
  localparam int C_COND    = 6;
  localparam int C_JMP     = 7;
  localparam int C_IRQ     = 8;
  localparam int C_INDCALL = 9;
  localparam int C_ABORT   = 10;
  localparam int C_ZCALL   = 11;
  localparam int C_INDJMP  = 12;

  typedef logic [NCLASS-1:0] cls_t;
  typedef logic [1:0]        plm_t;

  localparam plm_t PLM_USER   = 2'b01;
  localparam plm_t PLM_KERNEL = 2'b10;
endpackage

// File: rtl/brc_opcode_dec.sv
module brc_opcode_dec
  import brc_pkg::*;
#(
  parameter int MAX_BYTES   = 6,
  parameter int DISP_LONG   = 4,
  parameter int DISP_LEGACY = 4,
  parameter int CNT_W       = $clog2(MAX_BYTES + 1)
) (
  input  logic [8*MAX_BYTES-1:0] bytes,
  input  logic [CNT_W-1:0]       nbytes,
  input  logic                   long_mode,
  output cls_t                   cls
);
  logic [7:0] ob [MAX_BYTES];

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_unpack
    assign ob[g] = bytes[8*g +: 8];
  end

  int   dlen;
  int   navail;
  logic disp_nz;
  logic [2:0] modrm_reg;

  always_comb begin
    dlen      = long_mode ? DISP_LONG : DISP_LEGACY;
    navail    = int'(nbytes);
    modrm_reg = ob[1][5:3];
    disp_nz   = 1'b0;
    for (int i = 1; i < MAX_BYTES; i++) begin
      if (i <= dlen && ob[i] != 8'h00) disp_nz = 1'b1;
    end

    cls = '0;
    if (navail >= 1) begin
      if (ob[0] == 8'h0F) begin
        if (navail >= 2) begin
          case (ob[1]) inside
            8'h05, 8'h34:    cls[C_SYSCALL] = 1'b1;
            8'h07, 8'h35:    cls[C_SYSRET]  = 1'b1;
            [8'h80:8'h8F]:   cls[C_COND]    = 1'b1;
            default:         cls = '0;
          endcase
        end
      end else begin
        case (ob[0]) inside
          [8'h70:8'h7F], [8'hE0:8'hE3]:     cls[C_COND]  = 1'b1;
          8'hC2, 8'hC3, 8'hCA, 8'hCB:       cls[C_RET]   = 1'b1;
          8'hCF:                            cls[C_IRET]  = 1'b1;
          [8'hCC:8'hCE]:                    cls[C_SWINT] = 1'b1;
          [8'hE9:8'hEB]:                    cls[C_JMP]   = 1'b1;
          8'h9A:                            cls[C_CALL]  = 1'b1;
          8'hE8: begin
            if (navail >= 1 + dlen) begin
              if (disp_nz) cls[C_CALL]  = 1'b1;
              else         cls[C_ZCALL] = 1'b1;
            end
          end
          8'hFF: begin
            if (navail >= 2) begin
              case (modrm_reg)
                3'd2, 3'd3: cls[C_INDCALL] = 1'b1;
                3'd4, 3'd5: cls[C_INDJMP]  = 1'b1;
                default:    cls = '0;
              endcase
            end
          end
          default: cls = '0;
        endcase
      end
    end
  end

  always_comb begin
    assert ($onehot0(cls)) else $error("a_r12_dec_onehot");
  end
endmodule

// File: rtl/brc_priv_fix.sv
module brc_priv_fix
  import brc_pkg::*;
(
  input  cls_t dec_cls,
  input  logic no_bytes,
  input  logic src_kernel,
  input  logic dst_kernel,
  input  logic abort_f,
  input  logic src_zero,
  input  logic dst_zero,
  output cls_t cls,
  output plm_t plm
);
  logic ring_up;

  assign ring_up = !src_kernel && dst_kernel;

  always_comb begin
    cls = '0;
    if (src_zero || dst_zero) begin
      cls = '0;
    end else if (abort_f) begin
      cls[C_ABORT] = 1'b1;
    end else if (no_bytes) begin
      cls = '0;
    end else if (ring_up && !dec_cls[C_SYSCALL] && !dec_cls[C_SWINT]) begin
      cls[C_IRQ] = 1'b1;
    end else begin
      cls = dec_cls;
    end
    plm = (cls == '0) ? plm_t'(2'b00) : (dst_kernel ? PLM_KERNEL : PLM_USER);
  end
endmodule

// File: rtl/brc_classifier.sv
module brc_classifier
  import brc_pkg::*;
#(
  parameter int MAX_BYTES   = 6,
  parameter int DISP_LONG   = 4,
  parameter int DISP_LEGACY = 4,
  localparam int CNT_W      = $clog2(MAX_BYTES + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [8*MAX_BYTES-1:0]    in_bytes,
  input  logic [CNT_W-1:0]          in_nbytes,
  input  logic                      in_long_mode,
  input  logic                      in_src_kernel,
  input  logic                      in_dst_kernel,
  input  logic                      in_abort,
  input  logic                      in_src_zero,
  input  logic                      in_dst_zero,
  output logic                      out_valid,
  output logic [NCLASS-1:0]         out_class,
  output logic [1:0]                out_plm
);
  cls_t dec_cls, fix_cls;
  plm_t fix_plm;

  brc_opcode_dec #(
    .MAX_BYTES  (MAX_BYTES),
    .DISP_LONG  (DISP_LONG),
    .DISP_LEGACY(DISP_LEGACY),
    .CNT_W      (CNT_W)
  ) u_dec (
    .bytes    (in_bytes),
    .nbytes   (in_nbytes),
    .long_mode(in_long_mode),
    .cls      (dec_cls)
  );

  brc_priv_fix u_fix (
    .dec_cls   (dec_cls),
    .no_bytes  (in_nbytes == '0),
    .src_kernel(in_src_kernel),
    .dst_kernel(in_dst_kernel),
    .abort_f   (in_abort),
    .src_zero  (in_src_zero),
    .dst_zero  (in_dst_zero),
    .cls       (fix_cls),
    .plm       (fix_plm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_class <= '0;
      out_plm   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_class <= fix_cls;
        out_plm   <= fix_plm;
      end
    end
  end

  // R1: strobe follows input by one cycle
  a_r1_strobe: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r1_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R12: at most one class bit
  a_r12_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_class));
  // R11: tag present exactly when a class is present
  a_r11_plm: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_plm) && ((out_plm != 2'b00) == (out_class != '0)));
  // R2: zero address wins
  a_r2_zero_addr: assert property (@(posedge clk) disable iff (rst)
    in_valid && (in_src_zero || in_dst_zero) |=> out_class == '0);
  // R3: abort with target tag
  a_r3_abort: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_abort && !in_src_zero && !in_dst_zero && in_dst_kernel
    |=> out_class == cls_t'(1 << C_ABORT) && out_plm == PLM_KERNEL);
  // R4: nothing readable gives none
  a_r4_no_bytes: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_abort && in_nbytes == '0 |=> out_class == '0);
  // R10: user-to-kernel leaves only as irq, syscall or software interrupt
  a_r10_ring_up: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_src_zero && !in_dst_zero && !in_abort && in_nbytes != '0
    && !in_src_kernel && in_dst_kernel
    |=> (out_class[C_IRQ] || out_class[C_SYSCALL] || out_class[C_SWINT]));
endmodule

// File: tb/brc_classifier_tb.sv
`timescale 1ns/1ps
module brc_classifier_tb;
  localparam logic [12:0] K_NONE = 13'd0;
  localparam logic [12:0] K_CALL = 13'd1 << 0,  K_RET = 13'd1 << 1,
                          K_SYSC = 13'd1 << 2,  K_SYSR = 13'd1 << 3,
                          K_SWI  = 13'd1 << 4,  K_IRET = 13'd1 << 5,
                          K_COND = 13'd1 << 6,  K_JMP = 13'd1 << 7,
                          K_IRQ  = 13'd1 << 8,  K_ICALL = 13'd1 << 9,
                          K_ABRT = 13'd1 << 10, K_ZCALL = 13'd1 << 11,
                          K_IJMP = 13'd1 << 12;
  localparam logic [1:0]  P_U = 2'b01, P_K = 2'b10, P_N = 2'b00;

  logic clk = 0, rst = 1;
  logic in_valid = 0;
  logic [47:0] in_bytes = '0;
  logic [2:0] in_nbytes = '0;
  logic in_long_mode = 1, in_src_kernel = 0, in_dst_kernel = 0;
  logic in_abort = 0, in_src_zero = 0, in_dst_zero = 0;
  logic out_valid;
  logic [12:0] out_class;
  logic [1:0] out_plm;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  brc_classifier u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bytes(in_bytes),
    .in_nbytes(in_nbytes), .in_long_mode(in_long_mode),
    .in_src_kernel(in_src_kernel), .in_dst_kernel(in_dst_kernel),
    .in_abort(in_abort), .in_src_zero(in_src_zero), .in_dst_zero(in_dst_zero),
    .out_valid(out_valid), .out_class(out_class), .out_plm(out_plm));

  function automatic logic [47:0] pk(input logic [7:0] b0, b1, b2, b3, b4, b5);
    return {b5, b4, b3, b2, b1, b0};
  endfunction

  task automatic chk(input string tag, input logic [12:0] ec, input logic [1:0] ep);
    n_chk++;
    if (out_valid !== 1'b1 || out_class !== ec || out_plm !== ep) begin
      n_fail++;
      $display("FAIL %s: valid=%b class=%h plm=%b expected valid=1 class=%h plm=%b",
               tag, out_valid, out_class, out_plm, ec, ep);
    end
  endtask

  // drive at a falling edge, result is registered at the next rising edge
  task automatic run(input string tag, input logic [47:0] b, input logic [2:0] n,
                     input logic sk, dk, input logic [12:0] ec, input logic [1:0] ep);
    @(negedge clk);
    in_valid = 1; in_bytes = b; in_nbytes = n;
    in_src_kernel = sk; in_dst_kernel = dk;
    @(negedge clk);
    in_valid = 0;
    chk(tag, ec, ep);
    in_abort = 0; in_src_zero = 0; in_dst_zero = 0; in_long_mode = 1;
  endtask

  task automatic t_reset;
    n_chk++;
    if (out_valid !== 0 || out_class !== 0 || out_plm !== 0) begin
      n_fail++;
      $display("FAIL R1 reset: valid=%b class=%h plm=%b expected 0/0/0",
               out_valid, out_class, out_plm);
    end
  endtask

  task automatic t_strobe;
    run("R1 strobe", pk(8'hC3,0,0,0,0,0), 3'd1, 0, 0, K_RET, P_U);
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 idle: valid=%b expected 0", out_valid);
    end
  endtask

  task automatic t_zero_addr;
    in_src_zero = 1; in_abort = 1;
    run("R2 src zero over abort", pk(8'hE9,0,0,0,0,0), 3'd1, 0, 1, K_NONE, P_N);
    in_dst_zero = 1;
    run("R2 dst zero", pk(8'hC3,0,0,0,0,0), 3'd1, 1, 1, K_NONE, P_N);
  endtask

  task automatic t_abort;
    in_abort = 1;
    run("R3 abort kernel", pk(8'hE9,0,0,0,0,0), 3'd1, 0, 1, K_ABRT, P_K);
    in_abort = 1;
    run("R3 abort no bytes user", '0, 3'd0, 1, 0, K_ABRT, P_U);
  endtask

  task automatic t_no_bytes;
    run("R4 none ring up", pk(8'hE9,0,0,0,0,0), 3'd0, 0, 1, K_NONE, P_N);
  endtask

  task automatic t_twobyte;
    run("R5 0F05", pk(8'h0F,8'h05,0,0,0,0), 3'd2, 1, 1, K_SYSC, P_K);
    run("R5 0F34", pk(8'h0F,8'h34,0,0,0,0), 3'd2, 0, 0, K_SYSC, P_U);
    run("R5 0F07", pk(8'h0F,8'h07,0,0,0,0), 3'd2, 1, 0, K_SYSR, P_U);
    run("R5 0F35", pk(8'h0F,8'h35,0,0,0,0), 3'd6, 1, 0, K_SYSR, P_U);
    run("R5 0F8A", pk(8'h0F,8'h8A,0,0,0,0), 3'd2, 1, 1, K_COND, P_K);
    run("R9 0F truncated", pk(8'h0F,8'h05,0,0,0,0), 3'd1, 1, 1, K_NONE, P_N);
    run("R9 0F other", pk(8'h0F,8'h90,0,0,0,0), 3'd2, 1, 1, K_NONE, P_N);
  endtask

  task automatic t_single;
    run("R6 70", pk(8'h70,0,0,0,0,0), 3'd1, 0, 0, K_COND, P_U);
    run("R6 7F", pk(8'h7F,0,0,0,0,0), 3'd1, 1, 1, K_COND, P_K);
    run("R6 E3", pk(8'hE3,0,0,0,0,0), 3'd1, 0, 0, K_COND, P_U);
    run("R6 C2", pk(8'hC2,0,0,0,0,0), 3'd3, 1, 0, K_RET, P_U);
    run("R6 CB", pk(8'hCB,0,0,0,0,0), 3'd1, 1, 1, K_RET, P_K);
    run("R6 CF", pk(8'hCF,0,0,0,0,0), 3'd1, 1, 0, K_IRET, P_U);
    run("R6 CC", pk(8'hCC,0,0,0,0,0), 3'd1, 0, 0, K_SWI, P_U);
    run("R6 EB", pk(8'hEB,0,0,0,0,0), 3'd1, 0, 0, K_JMP, P_U);
    run("R6 9A", pk(8'h9A,0,0,0,0,0), 3'd1, 1, 1, K_CALL, P_K);
  endtask

  task automatic t_call;
    run("R7 E8 zero disp", pk(8'hE8,0,0,0,0,0), 3'd5, 0, 0, K_ZCALL, P_U);
    run("R7 E8 disp top byte", pk(8'hE8,0,0,0,8'h01,0), 3'd5, 0, 0, K_CALL, P_U);
    run("R7 E8 disp low byte", pk(8'hE8,8'h10,0,0,0,0), 3'd6, 1, 1, K_CALL, P_K);
    run("R7 E8 beyond disp ignored", pk(8'hE8,0,0,0,0,8'hFF), 3'd6, 1, 1, K_ZCALL, P_K);
    in_long_mode = 0;
    run("R7 E8 legacy mode", pk(8'hE8,0,0,0,8'h02,0), 3'd5, 0, 0, K_CALL, P_U);
    run("R9 E8 short", pk(8'hE8,0,0,0,0,0), 3'd4, 0, 0, K_NONE, P_N);
  endtask

  task automatic t_ff;
    run("R8 FF /2", pk(8'hFF,8'h10,0,0,0,0), 3'd2, 0, 0, K_ICALL, P_U);
    run("R8 FF /3", pk(8'hFF,8'h18,0,0,0,0), 3'd2, 1, 1, K_ICALL, P_K);
    run("R8 FF /4", pk(8'hFF,8'hE0,0,0,0,0), 3'd2, 0, 0, K_IJMP, P_U);
    run("R8 FF /5", pk(8'hFF,8'h28,0,0,0,0), 3'd2, 1, 1, K_IJMP, P_K);
    run("R8 FF /0", pk(8'hFF,8'hC7,0,0,0,0), 3'd2, 0, 0, K_NONE, P_N);
    run("R9 FF short", pk(8'hFF,8'h10,0,0,0,0), 3'd1, 0, 0, K_NONE, P_N);
  endtask

  task automatic t_unknown;
    run("R9 unknown 90", pk(8'h90,0,0,0,0,0), 3'd1, 1, 1, K_NONE, P_N);
  endtask

  task automatic t_fixup;
    run("R10 jmp ring up", pk(8'hE9,0,0,0,0,0), 3'd1, 0, 1, K_IRQ, P_K);
    run("R10 unknown ring up", pk(8'h90,0,0,0,0,0), 3'd1, 0, 1, K_IRQ, P_K);
    run("R10 syscall kept", pk(8'h0F,8'h05,0,0,0,0), 3'd2, 0, 1, K_SYSC, P_K);
    run("R10 swint kept", pk(8'hCD,0,0,0,0,0), 3'd2, 0, 1, K_SWI, P_K);
    run("R11 ret to user", pk(8'hC3,0,0,0,0,0), 3'd1, 1, 0, K_RET, P_U);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    t_strobe();
    t_zero_addr();
    t_abort();
    t_no_bytes();
    t_twobyte();
    t_single();
    t_call();
    t_ff();
    t_unknown();
    t_fixup();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule